// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level page table that sits in an external memory. The caller supplies the base address of the root table along with each translation request, and marks the request as a read or a write. The walker then reads the root-table entry chosen by the upper ten address bits. That entry names the frame of a second-level table. The walker then reads the entry chosen by the middle ten bits of that table. The leaf frame number joined to the low twelve bits of the virtual address forms the result.

All table reads leave through a single request/response port. A request is held until the memory accepts it. A response may arrive any number of cycles later. Only one walk runs at a time. When the walk ends, the result or a fault code appears for exactly one cycle. A missing root entry, a missing leaf entry and a write to a read-only leaf each return a different fault code.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The virtual address splits into a root index in bits 31:22, a table index in bits 21:12 and an offset in bits 11:0. For example, 0x00403004 gives root index 1, table index 3 and offset 4.
- R3: The first memory read of a walk goes to `root_base + 4*root_index`. `root_base` is sampled when the request is accepted.
- R4: The second memory read goes to `{F, 12'h000} + 4*table_index`, where F is bits 31:12 of the root entry.
- R5: A successful walk returns `rsp_paddr = {leaf bits 31:12, offset}` with `rsp_fault` = 0. Entry bits 2 to 4 do not affect the result, and neither does bit 1 of a root entry.
- R6: If bit 0 (present) of the root entry is 0, the walk ends with `rsp_fault` = 1 and `rsp_paddr` = 0, and no second read is issued.
- R7: If bit 0 of the leaf entry is 0, the walk ends with `rsp_fault` = 2 and `rsp_paddr` = 0.
- R8: If a write request meets a leaf entry with bit 1 (read-only) set, the walk ends with `rsp_fault` = 3 and `rsp_paddr` = 0. A read of the same page succeeds.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the cycle after the response. Requests offered in that window are ignored and start no walk.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with an unchanged address. The walker waits for `mem_rsp_valid` however many cycles it takes.
- R11: `rsp_valid` stays high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Byte address of the root table, sampled at request acceptance |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 root absent, 2 leaf absent, 3 write to read-only |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the 32-bit entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table entry |

## Verification
Most internal faults in this block become visible at the memory port before they reach the result. A wrong index field or a wrong table base changes `mem_req_addr` in the same cycle the read is issued. Because the bench logs both read addresses of every walk, such faults are caught one or two reads into the walk. A state register that skips or repeats a level shows up as a wrong number of memory reads, and a mis-latched offset or frame shows up as a wrong `rsp_paddr`; both are visible when the one-cycle response strobe fires. Stuck busy or idle handshake state shows at `req_ready` within a cycle, and it is checked by driving requests while a walk is running.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int IDX_W   = 10;
    localparam int OFF_W   = 12;
    localparam int ENT_B   = 4;
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int ENT_SH  = $clog2(ENT_B);
    localparam int SPARE_W = OFF_W - 5;

    typedef struct packed {
        logic [IDX_W-1:0] dir;
        logic [IDX_W-1:0] tab;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SPARE_W-1:0] spare;
        logic               nocache;
        logic               dirty;
        logic               used;
        logic               rdonly;
        logic               valid;
    } pte_t;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_DIR   = 2'd1,
        FLT_LEAF  = 2'd2,
        FLT_WPROT = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_REQ,
        S_DIR_WAIT,
        S_TAB_REQ,
        S_TAB_WAIT,
        S_DONE
    } walk_state_e;

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
        return base + (PA_W'(idx) << ENT_SH);
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]  tbl_base,
    input  logic [IDX_W-1:0] tbl_idx,
    output logic [PA_W-1:0]  ent_addr
);
    always_comb ent_addr = entry_addr(tbl_base, tbl_idx);
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]    raw_entry,
    input  logic               at_leaf,
    input  logic               is_write,
    output fault_e             fault,
    output logic [FRAME_W-1:0] frame
);
    pte_t ent;

    always_comb begin
        ent   = pte_t'(raw_entry);
        frame = ent.frame;
        if (!ent.valid)
            fault = at_leaf ? FLT_LEAF : FLT_DIR;
        else if (at_leaf && is_write && ent.rdonly)
            fault = FLT_WPROT;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic [PA_W-1:0]    root_base,
    output logic               req_ready,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  fault_e             ent_fault,
    input  logic [FRAME_W-1:0] ent_frame,
    output logic               at_leaf,
    output logic               wr_q,
    output logic [PA_W-1:0]    walk_base,
    output logic [IDX_W-1:0]   walk_idx,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output fault_e             rsp_fault
);
    walk_state_e       state;
    vaddr_t            va_q;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   paddr_q;
    fault_e            fault_q;

    always_comb begin
        req_ready     = (state == S_IDLE);
        mem_req_valid = (state == S_DIR_REQ) || (state == S_TAB_REQ);
        at_leaf       = (state == S_TAB_REQ) || (state == S_TAB_WAIT);
        walk_base     = base_q;
        walk_idx      = at_leaf ? va_q.tab : va_q.dir;
        rsp_valid     = (state == S_DONE);
        rsp_paddr     = paddr_q;
        rsp_fault     = fault_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    va_q    <= vaddr_t'(req_vaddr);
                    wr_q    <= req_write;
                    base_q  <= root_base;
                    paddr_q <= '0;
                    fault_q <= FLT_NONE;
                    state   <= S_DIR_REQ;
                end
                S_DIR_REQ: if (mem_req_ready) state <= S_DIR_WAIT;
                S_DIR_WAIT: if (mem_rsp_valid) begin
                    if (ent_fault != FLT_NONE) begin
                        fault_q <= ent_fault;
                        state   <= S_DONE;
                    end else begin
                        base_q  <= {ent_frame, {OFF_W{1'b0}}};
                        state   <= S_TAB_REQ;
                    end
                end
                S_TAB_REQ: if (mem_req_ready) state <= S_TAB_WAIT;
                S_TAB_WAIT: if (mem_rsp_valid) begin
                    fault_q <= ent_fault;
                    paddr_q <= (ent_fault == FLT_NONE) ? {ent_frame, va_q.off} : '0;
                    state   <= S_DONE;
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] root_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic [1:0]  rsp_fault,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    logic               at_leaf;
    logic               wr_q;
    logic [PA_W-1:0]    walk_base;
    logic [IDX_W-1:0]   walk_idx;
    fault_e             ent_fault;
    fault_e             fault_out;
    logic [FRAME_W-1:0] ent_frame;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .root_base     (root_base),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_fault     (ent_fault),
        .ent_frame     (ent_frame),
        .at_leaf       (at_leaf),
        .wr_q          (wr_q),
        .walk_base     (walk_base),
        .walk_idx      (walk_idx),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (fault_out)
    );

    ptw_addr_gen u_addr (
        .tbl_base (walk_base),
        .tbl_idx  (walk_idx),
        .ent_addr (mem_req_addr)
    );

    ptw_entry_eval u_eval (
        .raw_entry (mem_rsp_data),
        .at_leaf   (at_leaf),
        .is_write  (wr_q),
        .fault     (ent_fault),
        .frame     (ent_frame)
    );

    assign rsp_fault = fault_out;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [1:0]  rsp_fault,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr
);
    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid)); // R1

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid); // R9

    AST_RSP_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready); // R9

    AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R11

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0)); // R6
endmodule

bind pt_walker ptw_checker u_ptw_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] addr_log [0:7];
    int          rd_count = 0;
    int          lat = 0;
    logic        stall_mode = 1'b0;
    logic        pend = 1'b0;
    int          pend_cnt = 0;
    logic [31:0] pend_addr = '0;

    always #5 clk = ~clk;

    pt_walker uut (
        .clk           (clk),
        .rst           (rst),
        .root_base     (root_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'h0;
    endfunction

    // memory model: accepts a read, answers after lat+1 cycles
    always @(posedge clk) begin
        if (rst) begin
            pend          <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_req_ready <= 1'b1;
        end else begin
            mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (rd_count < 8) addr_log[rd_count] <= mem_req_addr;
                rd_count  <= rd_count + 1;
                pend      <= 1'b1;
                pend_cnt  <= lat;
                pend_addr <= mem_req_addr;
            end else if (pend) begin
                if (pend_cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= mem_read(pend_addr);
                    pend          <= 1'b0;
                end else begin
                    pend_cnt <= pend_cnt - 1;
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
                summary();
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // issue one walk; returns paddr/fault; noise=1 offers extra requests while busy
    task automatic walk(input logic [31:0] va, input logic wr, input logic noise,
                        output logic [31:0] pa, output logic [1:0] flt);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_count  = 0;
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = noise;
        req_vaddr = 32'hDEAD_B000;
        n = 0;
        while (!rsp_valid && n < 500) begin
            if (noise) chk("R9 busy during walk", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            n++;
        end
        if (noise) chk("R9 busy at response", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b0;
        chk("R11 response seen", {31'd0, rsp_valid}, 32'd1);
        pa  = rsp_paddr;
        flt = rsp_fault;
        @(negedge clk);
        chk("R11 single-cycle strobe", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_example(input string tag);
        logic [31:0] pa; logic [1:0] f;
        root_base = 32'h0001_0000;
        walk(32'h0040_3004, 1'b0, 1'b0, pa, f);
        chk({tag, " R2/R3 root read addr (index 1)"}, addr_log[0], 32'h0001_0004);
        chk({tag, " R2/R4 table read addr (index 3)"}, addr_log[1], 32'h0002_000C);
        chk({tag, " R5 paddr"}, pa, 32'h1234_5004);
        chk({tag, " R5 fault"}, {30'd0, f}, 32'd0);
        chk({tag, " R2 read count"}, rd_count, 32'd2);
    endtask

    task automatic t_top_corner();
        logic [31:0] pa; logic [1:0] f;
        root_base = 32'h0010_0000;
        walk(32'hFFFF_FFFF, 1'b1, 1'b0, pa, f);
        chk("R3 root addr index 1023", addr_log[0], 32'h0010_0FFC);
        chk("R4 table addr index 1023", addr_log[1], 32'h0030_0FFC);
        chk("R5 paddr with spare bits set", pa, 32'hABCD_EFFF);
        chk("R5 write ok on writable leaf", {30'd0, f}, 32'd0);
    endtask

    task automatic t_dir_absent();
        logic [31:0] pa; logic [1:0] f;
        root_base = 32'h0001_0000;
        walk(32'h0080_0000, 1'b0, 1'b0, pa, f);
        chk("R6 fault code", {30'd0, f}, 32'd1);
        chk("R6 paddr zero", pa, 32'd0);
        repeat (4) @(negedge clk);
        chk("R6 single read", rd_count, 32'd1);
    endtask

    task automatic t_leaf_absent();
        logic [31:0] pa; logic [1:0] f;
        root_base = 32'h0001_0000;
        walk(32'h0040_5010, 1'b0, 1'b0, pa, f);
        chk("R7 table addr", addr_log[1], 32'h0002_0014);
        chk("R7 fault code", {30'd0, f}, 32'd2);
        chk("R7 paddr zero", pa, 32'd0);
    endtask

    task automatic t_protect();
        logic [31:0] pa; logic [1:0] f;
        root_base = 32'h0001_0000;
        walk(32'h0040_6123, 1'b1, 1'b0, pa, f);
        chk("R8 write fault code", {30'd0, f}, 32'd3);
        chk("R8 write paddr zero", pa, 32'd0);
        walk(32'h0040_6123, 1'b0, 1'b0, pa, f);
        chk("R8 read fault code", {30'd0, f}, 32'd0);
        chk("R8 read paddr", pa, 32'h7777_7123);
    endtask

    task automatic t_stall();
        stall_mode = 1'b1;
        lat = 5;
        t_example("R10 stalled");
        stall_mode = 1'b0;
        lat = 0;
    endtask

    task automatic t_busy();
        logic [31:0] pa; logic [1:0] f;
        root_base = 32'h0001_0000;
        lat = 3;
        walk(32'h0040_3004, 1'b0, 1'b1, pa, f);
        chk("R9 first walk result kept", pa, 32'h1234_5004);
        chk("R9 no extra reads", rd_count, 32'd2);
        repeat (4) @(negedge clk);
        chk("R9 idle after walk", {31'd0, mem_req_valid}, 32'd0);
        chk("R9 ignored request started nothing", rd_count, 32'd2);
        lat = 0;
    endtask

    initial begin
        mem_img[32'h0001_0004] = 32'h0002_0001;
        mem_img[32'h0002_000C] = 32'h1234_5001;
        mem_img[32'h0010_0FFC] = 32'h0030_001F;
        mem_img[32'h0030_0FFC] = 32'hABCD_E01D;
        mem_img[32'h0001_0008] = 32'h0040_0000;
        mem_img[32'h0002_0014] = 32'h5555_5000;
        mem_img[32'h0002_0018] = 32'h7777_7003;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_example("base");
        t_top_corner();
        t_dir_absent();
        t_leaf_absent();
        t_protect();
        t_stall();
        t_busy();
        summary();
    end
endmodule